// File: doc/BRIEF.md
# SONET Serial Byte Aligner with Frame Hunt

This block turns a one-bit-per-clock NRZ line stream into bytes. It runs entirely in the bit-rate clock domain. Every eighth clock it loads a fresh byte onto its parallel output and raises a one-cycle byte strobe, so downstream logic can use the strobe as a clock enable instead of a derived byte clock. Bits arrive most significant first, and the earliest bit of each byte ends up in bit 7.

While the out-of-frame control is high, a 48-bit window is compared with the SONET/SDH framing run on every bit clock. The framing run is three A1 bytes (8'hF6) followed by three A2 bytes (8'h28). The comparison covers every bit offset. A match moves the byte boundary so that the third A2 appears whole on the output, and a frame pulse is raised for exactly that byte period. When out-of-frame is low, the alignment is frozen. One exception applies: a match that completes as out-of-frame is being released still counts. A loss-of-signal input blanks the parallel output to zero.

Top module: `sonet_byte_framer`

## Requirements
- R1: The serial input is sampled on each rising clock edge. Bits are assembled most significant first, so the earliest bit of a byte appears in byte_out bit 7. A new byte and a one-cycle byte_stb appear together.
- R2: When no re-alignment occurs, byte_stb is high for one cycle in every 8. After the synchronous reset is released, the first strobe is visible after the 8th rising edge.
- R3: Hunting is enabled while out_of_frame is high. If the bits F6 F6 F6 28 28 28 (hex, each MSB first) are received at any bit offset, the next byte_stb presents 8'h28, and the following bytes are aligned to that boundary.
- R4: frame_pulse rises only together with byte_stb and stays high for exactly 8 clock cycles, which is one byte period. It changes only in a byte_stb cycle.
- R5: While out_of_frame stays high after a frame has been found, a later framing run at a different bit offset re-aligns the bytes again and raises frame_pulse again.
- R6: While out_of_frame is low, and was also low one cycle earlier, a framing run neither moves the byte boundary nor raises frame_pulse.
- R7: Suppose out_of_frame is high at the edge that captures the last framing bit and low at the next edge. The frame is still taken, with alignment and frame_pulse. If out_of_frame is already low at the capturing edge, the frame is not taken.
- R8: While loss_of_signal is high, byte_out reads 8'h00 at once. byte_stb and frame_pulse are unaffected, and the held byte reappears when loss_of_signal drops.
- R9: A synchronous active-high reset clears the 48-bit window, the byte phase, byte_out, byte_stb and frame_pulse. Framing bits received before the reset cannot complete a match afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | NRZ serial data bit |
| out_of_frame | input | 1 | Level-sensitive hunt enable |
| loss_of_signal | input | 1 | Forces byte_out to zero |
| byte_out | output | 8 | Parallel byte, earliest bit in bit 7 |
| byte_stb | output | 1 | One-cycle strobe marking a new byte |
| frame_pulse | output | 1 | High for the byte period of the aligned third A2 |

## Verification
The bound checker watches several rules on every cycle. It checks the 8-cycle strobe spacing away from re-alignments, and that frame_pulse changes only with the strobe and is never raised unless out_of_frame was high in one of the two relevant cycles. It also checks that no boundary moves while the hunt is off, that a pulsed byte reads 8'h28, and that loss_of_signal blanks the output. Other behaviour is visible only in the bench scenarios. These include correct alignment at each of several bit offsets, MSB-first byte content after the frame, re-hunting at a new offset, and the exact edge timing of the out-of-frame release case. They also include the value held behind the loss-of-signal mask and the clearing of stale framing bits by reset.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned REPS   = 3;
  localparam logic [7:0]  A1_CODE = 8'hF6;
  localparam logic [7:0]  A2_CODE = 8'h28;

  // Hunt permission: held high, or released in this very cycle.
  function automatic logic hunt_gate(input logic oof_now, input logic oof_prev);
    return oof_now | (oof_prev & ~oof_now);
  endfunction

  // Lane 0 is the oldest byte of the window; the first REPS lanes carry A1.
  function automatic logic [7:0] lane_code(input int unsigned lane, input int unsigned reps,
                                           input logic [7:0] a1, input logic [7:0] a2);
    return (lane < reps) ? a1 : a2;
  endfunction
endpackage

// File: rtl/sbf_shift_window.sv
module sbf_shift_window #(
  parameter int unsigned WIN_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic [WIN_W-1:0] win
);
  always_ff @(posedge clk) begin
    if (rst) win <= '0;
    else     win <= {win[WIN_W-2:0], din};
  end
endmodule

// File: rtl/sbf_pattern_cmp.sv
module sbf_pattern_cmp #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned REPS   = 3,
  parameter logic [7:0]  A1     = 8'hF6,
  parameter logic [7:0]  A2     = 8'h28,
  localparam int unsigned LANES = 2 * REPS,
  localparam int unsigned WIN_W = LANES * BYTE_W
) (
  input  logic [WIN_W-1:0] win,
  output logic             hit
);
  logic [LANES-1:0] lane_ok;
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_ok[k] = (win[WIN_W-1-k*BYTE_W -: BYTE_W] ==
                         BYTE_W'(sbf_pkg::lane_code(k, REPS, A1, A2)));
  end
  assign hit = &lane_ok;
endmodule

// File: rtl/sbf_phase_ctr.sv
module sbf_phase_ctr #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PH_W = $clog2(BYTE_W)
) (
  input  logic clk,
  input  logic rst,
  input  logic realign,
  output logic boundary
);
  localparam logic [PH_W-1:0] LAST = PH_W'(BYTE_W - 1);
  logic [PH_W-1:0] ph;

  assign boundary = (ph == LAST) | realign;

  always_ff @(posedge clk) begin
    if (rst)           ph <= '0;
    else if (boundary) ph <= '0;
    else               ph <= ph + 1'b1;
  end
endmodule

// File: rtl/sonet_byte_framer.sv
module sonet_byte_framer #(
  parameter int unsigned BYTE_W = sbf_pkg::BYTE_W,
  parameter int unsigned REPS   = sbf_pkg::REPS,
  parameter logic [7:0]  A1     = sbf_pkg::A1_CODE,
  parameter logic [7:0]  A2     = sbf_pkg::A2_CODE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              out_of_frame,
  input  logic              loss_of_signal,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_stb,
  output logic              frame_pulse
);
  localparam int unsigned WIN_W = 2 * REPS * BYTE_W;

  logic [WIN_W-1:0]  win;
  logic              hit;
  logic              oof_q;
  logic              gate;
  logic              realign;
  logic              boundary;
  logic [BYTE_W-1:0] out_q;
  logic              stb_q;
  logic              fp_q;

  sbf_shift_window #(.WIN_W(WIN_W)) win_i (
    .clk(clk), .rst(rst), .din(ser_in), .win(win)
  );

  sbf_pattern_cmp #(.BYTE_W(BYTE_W), .REPS(REPS), .A1(A1), .A2(A2)) cmp_i (
    .win(win), .hit(hit)
  );

  assign gate    = sbf_pkg::hunt_gate(out_of_frame, oof_q);
  assign realign = hit & gate;

  sbf_phase_ctr #(.BYTE_W(BYTE_W)) ph_i (
    .clk(clk), .rst(rst), .realign(realign), .boundary(boundary)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oof_q <= 1'b0;
      out_q <= '0;
      stb_q <= 1'b0;
      fp_q  <= 1'b0;
    end else begin
      oof_q <= out_of_frame;
      stb_q <= boundary;
      if (boundary) begin
        out_q <= win[BYTE_W-1:0];
        fp_q  <= realign;
      end
    end
  end

  assign byte_out    = loss_of_signal ? '0 : out_q;
  assign byte_stb    = stb_q;
  assign frame_pulse = fp_q;
endmodule

// File: rtl/sbf_checker.sv
module sbf_checker #(
  parameter int unsigned BYTE_W = 8,
  parameter logic [7:0]  A2     = 8'h28
) (
  input logic              clk,
  input logic              rst,
  input logic              out_of_frame,
  input logic              loss_of_signal,
  input logic [BYTE_W-1:0] byte_out,
  input logic              byte_stb,
  input logic              frame_pulse,
  input logic              realign_w
);
  localparam int unsigned GW = $clog2(2 * BYTE_W) + 1;
  localparam logic [GW-1:0] GAP_FULL = GW'(BYTE_W);
  localparam logic [GW-1:0] GAP_MAX  = {GW{1'b1}};

  logic [GW-1:0] gap;
  logic [1:0]    age;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= '0;
      age <= '0;
    end else begin
      gap <= byte_stb ? GW'(1) : ((gap == GAP_MAX) ? GAP_MAX : gap + 1'b1);
      age <= (age == 2'd3) ? 2'd3 : age + 2'd1;
    end
  end

  assert_stb_period_R2: assert property (@(posedge clk) disable iff (rst)
    (byte_stb && !$past(realign_w)) |-> (gap == GAP_FULL));

  assert_fp_byte_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_pulse && byte_stb && !loss_of_signal) |-> (byte_out == BYTE_W'(A2)));

  assert_fp_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_pulse) |-> byte_stb);

  assert_fp_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !byte_stb |-> $stable(frame_pulse));

  assert_phase_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_stb && age >= 2'd2 && !$past(out_of_frame) && !$past(out_of_frame, 2))
      |-> (gap == GAP_FULL));

  assert_fp_gate_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(frame_pulse) && age >= 2'd2) |-> ($past(out_of_frame) || $past(out_of_frame, 2)));

  assert_los_zero_R8: assert property (@(posedge clk) disable iff (rst)
    loss_of_signal |-> (byte_out == '0));
endmodule

bind sonet_byte_framer sbf_checker #(.BYTE_W(BYTE_W), .A2(A2)) chk_i (
  .clk(clk), .rst(rst), .out_of_frame(out_of_frame), .loss_of_signal(loss_of_signal),
  .byte_out(byte_out), .byte_stb(byte_stb), .frame_pulse(frame_pulse), .realign_w(realign)
);

// File: tb/sonet_byte_framer_tb_top.sv
`timescale 1ns/1ps
module sonet_byte_framer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic oof = 1'b0;
  logic los = 1'b0;
  logic [7:0] byte_out;
  logic byte_stb;
  logic frame_pulse;

  localparam logic [7:0] C_A1 = 8'hF6;
  localparam logic [7:0] C_A2 = 8'h28;
  // {skew bits, payload byte}
  localparam int NSC = 4;
  localparam logic [10:0] SCEN [NSC] = '{ {3'd3, 8'h11}, {3'd5, 8'h44}, {3'd0, 8'hA5}, {3'd7, 8'h3C} };

  always #2.5 clk = ~clk;

  sonet_byte_framer dut_i (
    .clk(clk), .rst(rst), .ser_in(ser_in), .out_of_frame(oof), .loss_of_signal(los),
    .byte_out(byte_out), .byte_stb(byte_stb), .frame_pulse(frame_pulse)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int cyc = 0;
  int ln = 0;
  int fp_hi = 0;
  logic [7:0] lb [512];
  logic       lf [512];
  int         lc [512];

  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    if (byte_stb && ln < 512) begin
      lb[ln] = byte_out;
      lf[ln] = frame_pulse;
      lc[ln] = cyc;
      ln = ln + 1;
    end
    if (frame_pulse) fp_hi = fp_hi + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser_in = b;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  // mode 0: hunt held; 1: release one edge after the last bit; 2: release with the last bit
  task automatic run_frame(input int skew, input logic [7:0] pay, input int mode);
    for (int i = 0; i < skew; i++) send_bit(1'b0);
    send_byte(8'h00);
    send_byte(8'h00);
    for (int i = 0; i < 3; i++) send_byte(C_A1);
    send_byte(C_A2);
    send_byte(C_A2);
    for (int i = 7; i >= 1; i--) send_bit(C_A2[i]);
    @(negedge clk);
    ser_in = C_A2[0];
    if (mode == 2) oof = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      ser_in = pay[i];
      if (i == 7 && mode == 1) oof = 1'b0;
    end
    send_byte(8'h00);
    send_byte(8'h00);
  endtask

  function automatic int find_fp(input int mark);
    for (int i = mark; i < ln; i++) if (lf[i]) return i;
    return -1;
  endfunction

  function automatic int odd_gaps(input int mark);
    int n = 0;
    for (int i = (mark < 1 ? 1 : mark); i < ln; i++) if (lc[i] - lc[i-1] != 8) n++;
    return n;
  endfunction

  task automatic check_frame(input int mark, input int fh, input logic [7:0] pay, input string tag);
    int k;
    k = find_fp(mark);
    check(k >= 0, {tag, " R3 frame found"}, k, mark);
    if (k >= 0 && k + 1 < ln) begin
      check(lb[k] == C_A2, {tag, " R3 aligned A2"}, lb[k], C_A2);
      check(lb[k+1] == pay && !lf[k+1], {tag, " R1 payload byte"}, lb[k+1], pay);
      check(lc[k+1] - lc[k] == 8, {tag, " R2 spacing after frame"}, lc[k+1] - lc[k], 8);
    end
    check(fp_hi - fh == 8, {tag, " R4 pulse width"}, fp_hi - fh, 8);
  endtask

  initial begin
    int mark, fh, rel;
    // R9: reset state with noisy input
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ser_in = i[0];
    end
    #1;
    check(byte_out == 8'h00 && !byte_stb && !frame_pulse, "R9 reset outputs",
          {byte_out, byte_stb, frame_pulse}, 0);
    @(negedge clk);
    ser_in = 1'b0;
    rst = 1'b0;
    rel = cyc;
    mark = ln;
    for (int i = 0; i < 3; i++) send_byte(8'h00);
    check(ln > mark && lc[mark] - rel == 8, "R2 first strobe after reset", lc[mark] - rel, 8);
    check(odd_gaps(mark) == 0, "R2 strobe spacing", odd_gaps(mark), 0);

    // R3/R5: table of offsets with hunt held high
    oof = 1'b1;
    for (int i = 0; i < 4; i++) send_byte(8'h00);
    for (int s = 0; s < NSC; s++) begin
      logic [10:0] e;
      e = SCEN[s];
      mark = ln;
      fh = fp_hi;
      run_frame(int'(e[10:8]), e[7:0], 0);
      check_frame(mark, fh, e[7:0], s == 0 ? "table first" : "table R5 rehunt");
    end

    // R6: hunt off, phase frozen
    oof = 1'b0;
    send_byte(8'h00);
    send_byte(8'h00);
    mark = ln;
    fh = fp_hi;
    run_frame(3, 8'h5A, 0);
    check(find_fp(mark) < 0, "R6 no frame while hunt off", find_fp(mark), -1);
    check(odd_gaps(mark) == 0, "R6 phase frozen", odd_gaps(mark), 0);
    check(fp_hi - fh == 0, "R6 pulse stays low", fp_hi - fh, 0);

    // R7 positive: release one edge after the last framing bit
    oof = 1'b1;
    for (int i = 0; i < 4; i++) send_byte(8'h00);
    mark = ln;
    fh = fp_hi;
    run_frame(6, 8'hC3, 1);
    check_frame(mark, fh, 8'hC3, "R7 release case");

    // R7 negative: release at the capturing edge
    oof = 1'b1;
    for (int i = 0; i < 4; i++) send_byte(8'h00);
    mark = ln;
    fh = fp_hi;
    run_frame(2, 8'h96, 2);
    check(find_fp(mark) < 0, "R7 early release no frame", find_fp(mark), -1);
    check(fp_hi - fh == 0, "R7 early release pulse low", fp_hi - fh, 0);

    // R8: loss of signal masks output but not strobe or pulse
    oof = 1'b1;
    for (int i = 0; i < 4; i++) send_byte(8'h00);
    send_bit(1'b0);
    send_byte(8'h00);
    los = 1'b1;
    mark = ln;
    for (int i = 0; i < 3; i++) send_byte(C_A1);
    for (int i = 0; i < 3; i++) send_byte(C_A2);
    send_byte(8'hE7);
    send_bit(1'b0);
    @(negedge clk);
    los = 1'b0;
    ser_in = 1'b0;
    #1;
    check(byte_out == 8'hE7, "R8 held byte after loss clears", byte_out, 8'hE7);
    begin
      int k;
      k = find_fp(mark);
      check(k >= 0 && lb[k] == 8'h00, "R8 masked frame byte with pulse", k >= 0 ? lb[k] : 8'hFF, 0);
      check(k >= 0 && k + 1 < ln && lb[k+1] == 8'h00, "R8 masked payload", k + 1 < ln ? lb[k+1] : 8'hFF, 0);
    end
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    send_byte(8'h00);

    // R9: mid-run reset discards partial framing bits
    for (int i = 0; i < 3; i++) send_byte(C_A1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1;
    check(byte_out == 8'h00 && !byte_stb && !frame_pulse, "R9 mid-run reset outputs",
          {byte_out, byte_stb, frame_pulse}, 0);
    @(negedge clk);
    rst = 1'b0;
    mark = ln;
    fh = fp_hi;
    for (int i = 7; i >= 1; i--) send_bit(C_A2[i]);
    send_bit(C_A2[0]);
    send_byte(C_A2);
    send_byte(C_A2);
    send_byte(8'h00);
    send_byte(8'h00);
    check(find_fp(mark) < 0 && fp_hi - fh == 0, "R9 window cleared", fp_hi - fh, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule